// File: doc/BRIEF.md
# Address-Shared Serial Word Link

This block moves a parallel word of N bits across a single serial data line. A transmit side and a receive side work from one address bus. At each clock the transmit side picks the data bit named by the current address and places it on the line. The receive side decodes the same address and steers the line into that position of its word register.

A free-running address sequencer steps the address through every bit position while a run input is high, and holds it when run is low. An active-high enable gates the transmit side. A one-cycle strobe marks the point at which a full pass over all positions has been captured.

The pair needs only the log2(N) address lines plus the single data line between its two ends. Both ends sit in one module here, and the address and line are brought out so they can be observed.

Top module: `serial_link_pair`

## Requirements
- R1: While the active-low reset is asserted, the address reads 0, the received word reads all zeros and the valid strobe is low.
- R2: On each rising clock edge with run high, the address advances by one, and it wraps from N-1 to 0.
- R3: On a rising clock edge with run low, the address keeps its value.
- R4: With enable high, the serial line equals bit [address] of the transmit word, where bit 0 is the least significant bit.
- R5: With enable low, the serial line is 0 whatever the transmit word holds.
- R6: On a rising edge with run high, bit [address] of the received word takes the current line value, and every other bit keeps its value.
- R7: On a rising edge with run low, the received word does not change.
- R8: The valid strobe is high for exactly the one cycle that follows an edge at which run was high and the address was N-1. It is low in every other cycle.
- R9: Starting from address 0 with enable high and a steady transmit word, N run cycles leave a received word equal to the transmit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| run_i | input | 1 | Advances the address and captures the line when high |
| enable_i | input | 1 | Gates the transmit side; when low, the line is driven 0 |
| tx_word_i | input | N | Parallel word to send |
| addr_o | output | log2(N) | Shared address bus |
| line_o | output | 1 | Serial data line |
| rx_word_o | output | N | Reassembled word |
| word_valid_o | output | 1 | One-cycle strobe after the last position is captured |

## Verification
The embedded properties check, on every cycle, the following behaviours: the address stepping and holding, the line following the selected bit or being forced low, the capture of the line into the addressed bit, the freezing of the word while run is low, and the one-cycle valid strobe. Two behaviours can only be shown by the bench scenarios: that a whole pass really rebuilds the sent word, and that unaddressed bits survive across interleaved run, enable and word changes. The bench compares against its own model on every cycle for these.

// File: rtl/link_pkg.sv
package link_pkg;
  parameter int unsigned LINK_LANES_DEF = 4;

  function automatic bit lanes_ok(input int unsigned n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/link_addr_decoder.sv
module link_addr_decoder #(
  parameter int unsigned N  = link_pkg::LINK_LANES_DEF,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic [AW-1:0] addr_i,
  output logic [N-1:0]  sel_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_sel
    assign sel_o[gi] = (addr_i == AW'(gi));
  end
endmodule

// File: rtl/link_addr_seq.sv
module link_addr_seq #(
  parameter int unsigned N  = link_pkg::LINK_LANES_DEF,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (run_i) addr_d = addr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> addr_o == AW'($past(addr_o) + AW'(1)));
  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(addr_o));
endmodule

// File: rtl/link_tx_mux.sv
module link_tx_mux #(
  parameter int unsigned N  = link_pkg::LINK_LANES_DEF,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  data_i,
  output logic          line_o
);
  logic [N-1:0] sel;
  logic [N-1:0] gated;

  link_addr_decoder #(.N(N), .AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_gate
    assign gated[gi] = sel[gi] & data_i[gi];
  end

  assign line_o = enable_i & (|gated);

  // R4
  line_pick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |-> line_o == data_i[addr_i]);
  // R5
  line_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !line_o);
endmodule

// File: rtl/link_rx_demux.sv
module link_rx_demux #(
  parameter int unsigned N  = link_pkg::LINK_LANES_DEF,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [AW-1:0] addr_i,
  input  logic          line_i,
  output logic [N-1:0]  word_o,
  output logic          valid_o
);
  logic [N-1:0] sel;
  logic [N-1:0] word_q, word_d;
  logic         valid_q, valid_d;

  link_addr_decoder #(.N(N), .AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    always_comb begin
      word_d[gi] = word_q[gi];
      if (run_i && sel[gi]) word_d[gi] = line_i;
    end
  end

  always_comb valid_d = run_i & sel[N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  // R6
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> word_o[$past(addr_i)] == $past(line_i));
  // R7
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(word_o));
  // R8
  pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/serial_link_pair.sv
module serial_link_pair #(
  parameter int unsigned N  = link_pkg::LINK_LANES_DEF,
  parameter int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          enable_i,
  input  logic [N-1:0]  tx_word_i,
  output logic [AW-1:0] addr_o,
  output logic          line_o,
  output logic [N-1:0]  rx_word_o,
  output logic          word_valid_o
);
  logic [AW-1:0] addr;
  logic          line;

  initial begin
    if (!link_pkg::lanes_ok(N)) $error("lane count must be a power of two, at least 2");
  end

  link_addr_seq #(.N(N), .AW(AW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .addr_o (addr)
  );

  link_tx_mux #(.N(N), .AW(AW)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .addr_i   (addr),
    .data_i   (tx_word_i),
    .line_o   (line)
  );

  link_rx_demux #(.N(N), .AW(AW)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .addr_i  (addr),
    .line_i  (line),
    .word_o  (rx_word_o),
    .valid_o (word_valid_o)
  );

  assign addr_o = addr;
  assign line_o = line;
endmodule

// File: tb/serial_link_pair_tb.sv
module serial_link_pair_tb;
  localparam int N  = 4;
  localparam int AW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          en = 1'b0;
  logic [N-1:0]  word = '0;
  logic [AW-1:0] addr;
  logic          line;
  logic [N-1:0]  rx;
  logic          valid;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  bit checking = 0;

  int           m_addr = 0;
  logic [N-1:0] m_rx = '0;
  bit           m_valid = 0;
  bit           m_prev_run = 0;

  always #5 clk = ~clk;

  serial_link_pair #(.N(N)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .run_i        (run),
    .enable_i     (en),
    .tx_word_i    (word),
    .addr_o       (addr),
    .line_o       (line),
    .rx_word_o    (rx),
    .word_valid_o (valid)
  );

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; m_rx = '0; m_valid = 0; m_prev_run = 0;
    end else begin
      m_prev_run = run;
      if (run) begin
        m_valid = (m_addr == N - 1);
        m_rx[m_addr] = en ? word[m_addr] : 1'b0;
        m_addr = (m_addr + 1) % N;
      end else begin
        m_valid = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (checking && rst_n) begin
      check(m_prev_run ? "R2 address step" : "R3 address hold", int'(addr), m_addr);
      check(en ? "R4 line selects bit" : "R5 line forced low", int'(line),
            en ? int'(word[m_addr]) : 0);
      check(m_prev_run ? "R6 capture" : "R7 word frozen", int'(rx), int'(m_rx));
      check("R8 valid strobe", int'(valid), int'(m_valid));
    end
  end

  task automatic drive(input bit r, input bit e, input logic [N-1:0] w, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      run = r; en = e; word = w;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset address", int'(addr), 0);
    check("R1 reset word", int'(rx), 0);
    check("R1 reset valid", int'(valid), 0);
    #1 rst_n = 1'b1;
    checking = 1;
    // full pass with steady word: R9
    drive(1'b1, 1'b1, 4'b1011, N);
    @(negedge clk); #1 run = 1'b0;
    @(negedge clk);
    check("R9 word rebuilt", int'(rx), 32'hB);
    // hold with a changing word: R3, R7
    drive(1'b0, 1'b1, 4'b0100, 3);
    // second pass with another word
    drive(1'b1, 1'b1, 4'b0110, 2 * N);
    @(negedge clk); #1 run = 1'b0;
    @(negedge clk);
    check("R9 second word rebuilt", int'(rx), 32'h6);
    // enable low: R5, capture zeros
    drive(1'b1, 1'b0, 4'b1111, N);
    @(negedge clk); #1 run = 1'b0;
    @(negedge clk);
    check("R5 disabled pass clears word", int'(rx), 0);
    // mixed patterns
    for (int k = 0; k < 60; k++) begin
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
            N'($urandom), 1);
    end
    drive(1'b0, 1'b1, 4'b0000, 2);
    // reset mid-stream: R1
    drive(1'b1, 1'b1, 4'b1001, 2);
    @(negedge clk); #1 rst_n = 1'b0; run = 1'b0; checking = 0;
    @(negedge clk);
    check("R1 reset address again", int'(addr), 0);
    check("R1 reset word again", int'(rx), 0);
    check("R1 reset valid again", int'(valid), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule